// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This controller decides whether a protected output rail draws from the main supply or from a backup source. It works from digitized comparator flags. One flag says the main supply is above the reset threshold. Two margin flags compare the main supply against the backup source: one says main exceeds backup by the margin, the other says backup exceeds main by the margin. Every flag is brought into the clock domain through a synchronizer whose depth is a parameter.

From the synchronized flags a small mode machine drives two switch enables, one for the main path and one for the backup path. It changes between them with a one-cycle dead gap, so the two enables are never high together. It also raises a backup-mode flag.

While in backup mode the controller forces the power-fail warning low and holds the reset output low, and manual reset requests have no effect. Outside backup mode, the warning follows the synchronized power-fail comparison. The reset output is low whenever the main supply is under threshold or a manual reset is requested.

Top module: `supply_switchover_ctrl`

## Requirements
- R1: While the synchronized main-ok flag is 1, the controller never leaves main mode, whatever the two margin flags say.
- R2: With main-ok at 0, a main-above-backup flag of 1 keeps the controller in main mode, and in backup mode it starts the return to main.
- R3: Backup mode is entered only from main mode, and only when main-ok is 0, backup-above-main is 1 and main-above-backup is 0.
- R4: When main-ok is 0 and both margin flags are 0, the current mode is held in either mode. This is the hysteresis band.
- R5: `pf_warn_n` is 0 whenever the backup-mode flag is 1. Otherwise it is the inverse of the synchronized power-fail-low input (input 1 gives output 0).
- R6: `rst_out_n` is 0 whenever the backup-mode flag is 1, and `mr_req_raw` is then ignored. Otherwise `rst_out_n` is 0 exactly when main-ok is 0 or the manual reset request is 1.
- R7: With main-ok at 1, toggling or removing the backup-above-main flag causes neither a mode change nor a low on `rst_out_n`.
- R8: A change on a raw flag reaches `pf_warn_n` and `rst_out_n` after SYNC_STAGES clock edges. The first mode-state change follows one edge later.
- R9: On a mode change, both switch enables are 0 for exactly one cycle before the new enable rises. `backup_mode` already shows the target mode during that gap cycle.
- R10: While `rst_n` is low, both enables, `backup_mode` and `rst_out_n` are 0. In the first cycle after release both enables stay 0, and on the next edge `main_sw_en` rises.
- R11: `main_sw_en` and `bak_sw_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ok_raw | input | 1 | Main supply above reset threshold (asynchronous) |
| main_gt_bak_raw | input | 1 | Main exceeds backup by the margin (asynchronous) |
| bak_gt_main_raw | input | 1 | Backup exceeds main by the margin (asynchronous) |
| pf_low_raw | input | 1 | Monitored voltage below power-fail reference (asynchronous) |
| mr_req_raw | input | 1 | Manual reset request, active high (asynchronous) |
| main_sw_en | output | 1 | Enable of the main-supply switch |
| bak_sw_en | output | 1 | Enable of the backup switch |
| backup_mode | output | 1 | Controller is committed to backup mode |
| pf_warn_n | output | 1 | Power-fail warning, active low |
| rst_out_n | output | 1 | Reset output, active low |

## Verification
The bench walks through all 32 combinations of the five flag inputs many times, starting from both modes, and compares each one with an arithmetic model of the entry and exit rules. This catches an entry rule that ignores main-ok, which would drop to backup while the main supply is healthy. It also catches a missing main-above-backup term, which would flap between the modes.

Every transition is sampled in its gap cycle. A design that makes the new path before breaking the old one would show both enables high there, and one that skips the gap would show the new enable a cycle early.

Directed runs cover the remaining corners:
- Battery removal under a good main supply, where a wrong design would pulse reset.
- The dead band with both margin flags low, where a design without hysteresis would switch.
- Manual reset during backup, which must leave the outputs unchanged.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
   typedef enum logic [2:0] {
      ST_INIT    = 3'd0,
      ST_MAIN    = 3'd1,
      ST_TO_BAK  = 3'd2,
      ST_BAK     = 3'd3,
      ST_TO_MAIN = 3'd4
   } ssw_state_t;

   localparam int FLAG_N     = 5;
   localparam int FI_MAIN_OK = 0;
   localparam int FI_MAIN_GT = 1;
   localparam int FI_BAK_GT  = 2;
   localparam int FI_PF_LOW  = 3;
   localparam int FI_MR      = 4;
endpackage

// File: rtl/ssw_sync.sv
module ssw_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ssw_mode_fsm.sv
module ssw_mode_fsm
   import ssw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic main_ok,
   input  logic main_gt,
   input  logic bak_gt,
   output logic main_en,
   output logic bak_en,
   output logic bak_mode
);
   ssw_state_t st, st_nxt;

   always_comb begin
      st_nxt = st;
      case (st)
         ST_INIT:    st_nxt = ST_MAIN;
         ST_MAIN:    if (!main_ok && bak_gt && !main_gt) st_nxt = ST_TO_BAK;
         ST_TO_BAK:  st_nxt = ST_BAK;
         ST_BAK:     if (main_ok || main_gt) st_nxt = ST_TO_MAIN;
         ST_TO_MAIN: st_nxt = ST_MAIN;
         default:    st_nxt = ST_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st <= ST_INIT;
      else        st <= st_nxt;

   assign main_en  = (st == ST_MAIN);
   assign bak_en   = (st == ST_BAK);
   assign bak_mode = (st == ST_TO_BAK) || (st == ST_BAK);

   // R1
   main_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (main_ok && st == ST_MAIN) |=> st == ST_MAIN);
   // R9
   gap_to_bak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_TO_BAK |=> st == ST_BAK);
   // R9
   gap_to_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_TO_MAIN |=> st == ST_MAIN);
   // R10
   init_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_INIT |=> st == ST_MAIN);
endmodule

// File: rtl/ssw_out_gate.sv
module ssw_out_gate (
   input  logic bak_mode,
   input  logic main_ok,
   input  logic pf_low,
   input  logic mr_req,
   output logic pf_warn_n,
   output logic rst_out_n
);
   always_comb begin
      pf_warn_n = 1'b0;
      rst_out_n = 1'b0;
      if (!bak_mode) begin
         pf_warn_n = !pf_low;
         rst_out_n = main_ok && !mr_req;
      end
   end
endmodule

// File: rtl/supply_switchover_ctrl.sv
module supply_switchover_ctrl
   import ssw_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic main_ok_raw,
   input  logic main_gt_bak_raw,
   input  logic bak_gt_main_raw,
   input  logic pf_low_raw,
   input  logic mr_req_raw,
   output logic main_sw_en,
   output logic bak_sw_en,
   output logic backup_mode,
   output logic pf_warn_n,
   output logic rst_out_n
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [FLAG_N-1:0] flags_raw, flags_s;

   always_comb begin
      flags_raw             = '0;
      flags_raw[FI_MAIN_OK] = main_ok_raw;
      flags_raw[FI_MAIN_GT] = main_gt_bak_raw;
      flags_raw[FI_BAK_GT]  = bak_gt_main_raw;
      flags_raw[FI_PF_LOW]  = pf_low_raw;
      flags_raw[FI_MR]      = mr_req_raw;
   end

   ssw_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (flags_raw),
      .q     (flags_s)
   );

   ssw_mode_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .main_ok  (flags_s[FI_MAIN_OK]),
      .main_gt  (flags_s[FI_MAIN_GT]),
      .bak_gt   (flags_s[FI_BAK_GT]),
      .main_en  (main_sw_en),
      .bak_en   (bak_sw_en),
      .bak_mode (backup_mode)
   );

   ssw_out_gate u_gate (
      .bak_mode  (backup_mode),
      .main_ok   (flags_s[FI_MAIN_OK]),
      .pf_low    (flags_s[FI_PF_LOW]),
      .mr_req    (flags_s[FI_MR]),
      .pf_warn_n (pf_warn_n),
      .rst_out_n (rst_out_n)
   );

   // R11
   enable_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(main_sw_en && bak_sw_en));
   // R9
   bbm_to_bak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bak_sw_en) |-> !$past(main_sw_en));
   // R9
   bbm_to_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_sw_en) |-> !$past(bak_sw_en));
   // R5
   pf_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backup_mode |-> !pf_warn_n);
   // R6
   rst_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backup_mode |-> !rst_out_n);
   // R7
   no_entry_when_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_s[FI_MAIN_OK] && !backup_mode) |=> !backup_mode);
endmodule

// File: tb/supply_switchover_ctrl_test.sv
`timescale 1ns/1ps
module supply_switchover_ctrl_test;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_ok = 1'b0, m_gt = 1'b0, b_gt = 1'b0, pf = 1'b0, mr = 1'b0;
   logic main_sw_en, bak_sw_en, backup_mode, pf_warn_n, rst_out_n;
   int   nvec = 0, nbad = 0;
   logic mdl_bak = 1'b0;

   always #2 clk = ~clk;

   supply_switchover_ctrl #(.SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n),
      .main_ok_raw(m_ok), .main_gt_bak_raw(m_gt), .bak_gt_main_raw(b_gt),
      .pf_low_raw(pf), .mr_req_raw(mr),
      .main_sw_en(main_sw_en), .bak_sw_en(bak_sw_en), .backup_mode(backup_mode),
      .pf_warn_n(pf_warn_n), .rst_out_n(rst_out_n)
   );

   task automatic chk(input string req, input string what, input logic got, input logic exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic [4:0] c);
      m_ok = c[0]; m_gt = c[1]; b_gt = c[2]; pf = c[3]; mr = c[4];
   endtask

   // Applies a flag set, checks the gap cycle and the settled cycle against the model.
   task automatic apply(input logic [4:0] c, input string req);
      logic pre, nb;
      pre = mdl_bak;
      nb  = pre;
      if (!pre && !c[0] && c[2] && !c[1]) nb = 1'b1;   // R3 entry
      if (pre && (c[0] || c[1]))          nb = 1'b0;   // R2 exit
      drive(c);
      edges(LAT);
      chk(req, "gap main_sw_en", main_sw_en, (nb == pre) ? !pre : 1'b0);  // R9
      chk(req, "gap bak_sw_en",  bak_sw_en,  (nb == pre) ? pre : 1'b0);
      chk(req, "gap backup_mode", backup_mode, nb);
      chk(req, "pf_warn_n R5", pf_warn_n, !nb && !c[3]);
      chk(req, "rst_out_n R6", rst_out_n, !nb && c[0] && !c[4]);
      edges(1);
      chk(req, "main_sw_en", main_sw_en, !nb);
      chk(req, "bak_sw_en",  bak_sw_en,  nb);
      chk(req, "R11 exclusive", main_sw_en & bak_sw_en, 1'b0);
      mdl_bak = nb;
   endtask

   initial begin
      #(4 * 200000);
      nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      drive(5'b00011);
      edges(3);
      // R10 reset state
      chk("R10", "reset main_sw_en", main_sw_en, 1'b0);
      chk("R10", "reset bak_sw_en", bak_sw_en, 1'b0);
      chk("R10", "reset backup_mode", backup_mode, 1'b0);
      chk("R10", "reset rst_out_n", rst_out_n, 1'b0);
      rst_n = 1'b1;
      chk("R10", "first cycle main_sw_en", main_sw_en, 1'b0);
      edges(1);
      chk("R10", "after init main_sw_en", main_sw_en, 1'b1);
      chk("R8", "rst_out_n before sync", rst_out_n, 1'b0);
      edges(SYNC - 1);
      chk("R8", "rst_out_n after sync", rst_out_n, 1'b1);

      // R8 latency of a warning input
      pf = 1'b1;
      edges(SYNC - 1);
      chk("R8", "pf_warn_n one edge early", pf_warn_n, 1'b1);
      edges(1);
      chk("R8", "pf_warn_n on time", pf_warn_n, 1'b0);
      pf = 1'b0;
      edges(SYNC + 1);

      // R7 backup flag removed and restored while main is healthy
      for (int i = 0; i < 6; i++) begin
         b_gt = i[0];
         edges(LAT + 1);
         chk("R7", "main_sw_en", main_sw_en, 1'b1);
         chk("R7", "rst_out_n", rst_out_n, 1'b1);
         chk("R7", "backup_mode", backup_mode, 1'b0);
      end

      // R1 main ok with backup strongly higher
      apply(5'b00101, "R1");
      // R4 dead band in main mode
      apply(5'b00000, "R4");
      // R3 enter backup
      apply(5'b00100, "R3");
      // R4 dead band in backup mode
      apply(5'b00000, "R4");
      // R6 manual reset ignored in backup
      apply(5'b10100, "R6");
      // R5 power-fail forced in backup
      apply(5'b01100, "R5");
      // R2 return on main above backup
      apply(5'b00010, "R2");
      // R6 manual reset in main mode
      apply(5'b10001, "R6");

      // Near-exhaustive sweep over all flag combinations from both modes
      for (int k = 0; k < 160; k++) begin
         logic [4:0] c;
         c = 5'((k * 11 + 3) % 32);
         apply(c, "R3");
      end
      for (int k = 0; k < 32; k++) begin
         apply(5'b00100, "R3");
         apply(5'(k), "R2");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule